// File: doc/BRIEF.md
# Indexed Real-Time Clock Register File

This block is the register face of a real-time clock, reached through an index port and a data port. Software first writes an index, then reads or writes the selected register through the data port. Indices 0 through 9 select ten calendar bytes that are plain storage. Index 0x0A selects status register A and 0x0B selects status register B. Indices 0x0C and 0x0D are recognised but unsupported, and any data access to them is flagged. The block does not advance time. An initial time is placed into the calendar bytes through a separate one-cycle load port.

Only fixed configurations of registers A and B are legal. Any write that departs from them is refused and flagged. Register B carries a periodic-interrupt enable bit. This bit runs a free-running interval timer that raises a one-cycle interrupt request every `INTERVAL_CYCLES` clock cycles. Every read of register A inverts its update-in-progress bit, so a polling loop sees the bit change.

Top module: `rtc_index_regs`

## Requirements
- R1: An index write with a value above 0x0D is refused. The current index keeps its value, and `bad_index` is high for one cycle after the write edge. Index values 0x00 to 0x0D are accepted.
- R2: While the index is 0 to 9, a data write stores the byte at that slot. `dat_rdata` shows the stored byte of the selected slot.
- R3: Register A (index 0x0A) resets to 0x26. A data write of exactly 0x26 sets A to 0x26. Any other written value leaves A unchanged and raises `bad_config` for one cycle.
- R4: Register B (index 0x0B) resets to 0x46. Bit 6 is periodic enable, bit 3 is square-wave enable, bit 2 is binary mode and bit 1 is 24-hour mode. A write is accepted when its value with bits 6 and 3 cleared equals 0x06. Any other write leaves B unchanged and raises `bad_config` for one cycle.
- R5: An accepted B write with bit 6 set starts the interval timer only when the timer is idle, so a running timer keeps its phase. An accepted write with bit 6 clear stops the timer, and no interrupt follows.
- R6: While the timer runs, `irq` is a one-cycle pulse. The first pulse comes `INTERVAL_CYCLES` clock edges after reset release, or after the edge that starts the timer. Each following pulse comes `INTERVAL_CYCLES` edges after the one before it.
- R7: A data read of register A returns its current value. After the read edge, bit 7 of A (update in progress) is inverted.
- R8: A data read or write at index 0x0C or 0x0D raises `unimpl_access` for one cycle. Reads there return 0x00, and writes change nothing.
- R9: A `load_en` pulse stores seconds at slot 0, minutes at slot 2, hours at slot 4, the weekday plus one (`load_wday` 0..6 becomes 1..7) at slot 6, day of month at slot 7, month at slot 8 and year at slot 9. Slots 1, 3 and 5 keep their values.
- R10: After reset the index is 0, all calendar bytes are 0x00, and `bad_index`, `bad_config`, `unimpl_access` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Index write strobe |
| idx_wdata | input | 8 | Index value to write |
| dat_we | input | 1 | Data write strobe for the indexed register |
| dat_re | input | 1 | Data read strobe (side effects only) |
| dat_wdata | input | 8 | Data write value |
| dat_rdata | output | 8 | Value of the indexed register (combinational) |
| load_en | input | 1 | One-cycle pulse that loads the initial time |
| load_sec | input | 8 | Seconds to load |
| load_min | input | 8 | Minutes to load |
| load_hour | input | 8 | Hours to load |
| load_wday | input | 3 | Weekday 0..6, stored plus one |
| load_mday | input | 8 | Day of month to load |
| load_month | input | 8 | Month to load |
| load_year | input | 8 | Year to load |
| irq | output | 1 | Periodic interrupt request pulse |
| bad_index | output | 1 | Pulse: refused index write |
| bad_config | output | 1 | Pulse: refused write to register A or B |
| unimpl_access | output | 1 | Pulse: data access to index 0x0C or 0x0D |

## Verification
The bench writes register B with periodic enable set while the timer is already running. A design that restarts the timer on every such write would move the next pulse late by half an interval. It clears enable and then watches for three intervals, which catches a timer that keeps firing, and it measures the first pulse after a restart to catch an off-by-one in the reload. It reads register A three times in a row to show that bit 7 alternates, and tries out-of-range indices, illegal A and B values and the 0x0C/0x0D window. A design that moved the index, stored the bad value or read back a stale byte would fail there. The load check shows that the weekday gains one and that the alarm slots 1, 3 and 5 keep their values.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef logic [7:0] byte_t;

    // Register window
    localparam byte_t IDX_REG_A   = 8'h0A;
    localparam byte_t IDX_REG_B   = 8'h0B;
    localparam byte_t IDX_REG_C   = 8'h0C;
    localparam byte_t IDX_LAST    = 8'h0D;

    // Calendar slot positions decoded by software
    localparam int unsigned SLOT_SEC  = 0;
    localparam int unsigned SLOT_MIN  = 2;
    localparam int unsigned SLOT_HOUR = 4;
    localparam int unsigned SLOT_WDAY = 6;
    localparam int unsigned SLOT_MDAY = 7;
    localparam int unsigned SLOT_MON  = 8;
    localparam int unsigned SLOT_YEAR = 9;
    localparam int unsigned MIN_SLOTS = 10;

    // Register A: time base 32.768 kHz (bits 6:4 = 010) with 1024 Hz rate (bits 3:0 = 0110)
    localparam byte_t       A_RESET    = 8'h26;
    localparam int unsigned A_BUSY_BIT = 7;

    // Register B: periodic enable | binary | 24-hour
    localparam byte_t       B_RESET     = 8'h46;
    localparam byte_t       B_FREE_MASK = 8'h48;
    localparam byte_t       B_FIXED     = 8'h06;
    localparam int unsigned B_PIE_BIT   = 6;

    function automatic logic b_value_ok(byte_t v);
        return (v & ~B_FREE_MASK) == B_FIXED;
    endfunction

endpackage

// File: rtl/rtc_index_port.sv
module rtc_index_port #(
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned MAX_IDX = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] wdata_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             bad_o
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             bad;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.bad = 1'b0;
        if (we_i) begin
            if (wdata_i > IDX_W'(MAX_IDX)) begin
                st_d.bad = 1'b1;
            end else begin
                st_d.idx = wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o = st_q.idx;
    assign bad_o = st_q.bad;

endmodule

// File: rtl/rtc_cal_bytes.sv
module rtc_cal_bytes
    import rtc_pkg::*;
#(
    parameter int unsigned NUM   = 10,
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] sel_i,
    input  logic             wr_i,
    input  byte_t            wdata_i,
    input  logic             load_i,
    input  byte_t            ld_sec_i,
    input  byte_t            ld_min_i,
    input  byte_t            ld_hour_i,
    input  logic [2:0]       ld_wday_i,
    input  byte_t            ld_mday_i,
    input  byte_t            ld_mon_i,
    input  byte_t            ld_year_i,
    output byte_t            rdata_o
);

    typedef logic [NUM-1:0][7:0] bank_t;

    bank_t bank_d, bank_q;
    logic [NUM-1:0] hit;

    // Per-slot select lines
    for (genvar g = 0; g < NUM; g++) begin : g_hit
        assign hit[g] = (sel_i == IDX_W'(g));
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM; i++) begin
            if (wr_i && hit[i]) begin
                bank_d[i] = wdata_i;
            end
        end
        if (load_i) begin
            bank_d[SLOT_SEC]  = ld_sec_i;
            bank_d[SLOT_MIN]  = ld_min_i;
            bank_d[SLOT_HOUR] = ld_hour_i;
            bank_d[SLOT_WDAY] = {5'b0, ld_wday_i} + 8'd1;
            bank_d[SLOT_MDAY] = ld_mday_i;
            bank_d[SLOT_MON]  = ld_mon_i;
            bank_d[SLOT_YEAR] = ld_year_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM; i++) begin
            if (hit[i]) begin
                rdata_o = bank_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

endmodule

// File: rtl/rtc_status_regs.sv
module rtc_status_regs
    import rtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sel_a_i,
    input  logic  sel_b_i,
    input  logic  sel_cd_i,
    input  logic  wr_i,
    input  logic  rd_i,
    input  byte_t wdata_i,
    input  logic  run_i,
    output byte_t reg_a_o,
    output byte_t reg_b_o,
    output logic  bad_o,
    output logic  unimpl_o,
    output logic  start_o,
    output logic  stop_o
);

    typedef struct packed {
        byte_t a;
        byte_t b;
        logic  bad;
        logic  unimpl;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.bad    = 1'b0;
        st_d.unimpl = 1'b0;
        start_o     = 1'b0;
        stop_o      = 1'b0;

        if (sel_a_i) begin
            if (wr_i) begin
                if (wdata_i == A_RESET) begin
                    st_d.a = A_RESET;
                end else begin
                    st_d.bad = 1'b1;
                end
            end else if (rd_i) begin
                st_d.a[A_BUSY_BIT] = ~st_q.a[A_BUSY_BIT];
            end
        end

        if (sel_b_i && wr_i) begin
            if (b_value_ok(wdata_i)) begin
                st_d.b = wdata_i;
                if (wdata_i[B_PIE_BIT]) begin
                    start_o = ~run_i;
                end else begin
                    stop_o  = run_i;
                end
            end else begin
                st_d.bad = 1'b1;
            end
        end

        if (sel_cd_i && (wr_i || rd_i)) begin
            st_d.unimpl = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.a      <= A_RESET;
            st_q.b      <= B_RESET;
            st_q.bad    <= 1'b0;
            st_q.unimpl <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_a_o  = st_q.a;
    assign reg_b_o  = st_q.b;
    assign bad_o    = st_q.bad;
    assign unimpl_o = st_q.unimpl;

endmodule

// File: rtl/rtc_period_timer.sv
module rtc_period_timer #(
    parameter int unsigned INTERVAL = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    output logic run_o,
    output logic irq_o
);

    localparam int unsigned CNT_W  = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(INTERVAL - 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (stop_i) begin
            st_d.run = 1'b0;
        end else if (start_i) begin
            st_d.run = 1'b1;
            st_d.cnt = RELOAD;
        end else if (st_q.run) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = RELOAD;
                st_d.irq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.run <= 1'b1;
            st_q.cnt <= RELOAD;
            st_q.irq <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o = st_q.run;
    assign irq_o = st_q.irq;

endmodule

// File: rtl/rtc_index_regs.sv
module rtc_index_regs
    import rtc_pkg::*;
#(
    parameter int unsigned INTERVAL_CYCLES = 1024,
    parameter int unsigned CAL_SLOTS       = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_we,
    input  logic [7:0] idx_wdata,
    input  logic       dat_we,
    input  logic       dat_re,
    input  logic [7:0] dat_wdata,
    output logic [7:0] dat_rdata,
    input  logic       load_en,
    input  logic [7:0] load_sec,
    input  logic [7:0] load_min,
    input  logic [7:0] load_hour,
    input  logic [2:0] load_wday,
    input  logic [7:0] load_mday,
    input  logic [7:0] load_month,
    input  logic [7:0] load_year,
    output logic       irq,
    output logic       bad_index,
    output logic       bad_config,
    output logic       unimpl_access
);

    localparam int unsigned IDX_W = 8;

    byte_t cur_idx;
    byte_t cal_rdata;
    byte_t reg_a;
    byte_t reg_b;
    logic  sel_cal, sel_a, sel_b, sel_cd;
    logic  tmr_start, tmr_stop, timer_run;

    rtc_index_port #(
        .IDX_W   (IDX_W),
        .MAX_IDX (int'(IDX_LAST))
    ) u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (idx_we),
        .wdata_i (idx_wdata),
        .idx_o   (cur_idx),
        .bad_o   (bad_index)
    );

    assign sel_cal = (cur_idx < IDX_W'(CAL_SLOTS));
    assign sel_a   = (cur_idx == IDX_REG_A);
    assign sel_b   = (cur_idx == IDX_REG_B);
    assign sel_cd  = (cur_idx >= IDX_REG_C) && (cur_idx <= IDX_LAST);

    rtc_cal_bytes #(
        .NUM   (CAL_SLOTS),
        .IDX_W (IDX_W)
    ) u_cal (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (cur_idx),
        .wr_i      (dat_we && sel_cal),
        .wdata_i   (dat_wdata),
        .load_i    (load_en),
        .ld_sec_i  (load_sec),
        .ld_min_i  (load_min),
        .ld_hour_i (load_hour),
        .ld_wday_i (load_wday),
        .ld_mday_i (load_mday),
        .ld_mon_i  (load_month),
        .ld_year_i (load_year),
        .rdata_o   (cal_rdata)
    );

    rtc_status_regs u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_a_i  (sel_a),
        .sel_b_i  (sel_b),
        .sel_cd_i (sel_cd),
        .wr_i     (dat_we),
        .rd_i     (dat_re),
        .wdata_i  (dat_wdata),
        .run_i    (timer_run),
        .reg_a_o  (reg_a),
        .reg_b_o  (reg_b),
        .bad_o    (bad_config),
        .unimpl_o (unimpl_access),
        .start_o  (tmr_start),
        .stop_o   (tmr_stop)
    );

    rtc_period_timer #(
        .INTERVAL (INTERVAL_CYCLES)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .stop_i  (tmr_stop),
        .run_o   (timer_run),
        .irq_o   (irq)
    );

    always_comb begin
        if (sel_cal) begin
            dat_rdata = cal_rdata;
        end else if (sel_a) begin
            dat_rdata = reg_a;
        end else if (sel_b) begin
            dat_rdata = reg_b;
        end else begin
            dat_rdata = '0;
        end
    end

endmodule

// File: rtl/rtc_index_regs_chk.sv
module rtc_index_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       idx_we,
    input logic [7:0] idx_wdata,
    input logic       dat_we,
    input logic       dat_re,
    input logic [7:0] dat_wdata,
    input logic [7:0] cur_idx,
    input logic [7:0] reg_a,
    input logic [7:0] reg_b,
    input logic       irq,
    input logic       bad_index,
    input logic       bad_config,
    input logic       unimpl_access,
    input logic       timer_run
);

    assert_idx_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cur_idx <= 8'h0D);

    assert_bad_idx_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_we && idx_wdata > 8'h0D) |=> (bad_index && cur_idx == $past(cur_idx)));

    assert_a_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && cur_idx == 8'h0A && dat_wdata != 8'h26) |=> (bad_config && reg_a == $past(reg_a)));

    assert_b_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && cur_idx == 8'h0B && (dat_wdata & 8'hB7) != 8'h06) |=> (bad_config && reg_b == $past(reg_b)));

    assert_run_tracks_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        timer_run == reg_b[6]);

    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> reg_b[6]);

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_a_busy_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_re && !dat_we && cur_idx == 8'h0A) |=> (reg_a[7] != $past(reg_a[7])));

    assert_cd_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((dat_we || dat_re) && cur_idx >= 8'h0C) |=> unimpl_access);

endmodule

bind rtc_index_regs rtc_index_regs_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .idx_we        (idx_we),
    .idx_wdata     (idx_wdata),
    .dat_we        (dat_we),
    .dat_re        (dat_re),
    .dat_wdata     (dat_wdata),
    .cur_idx       (cur_idx),
    .reg_a         (reg_a),
    .reg_b         (reg_b),
    .irq           (irq),
    .bad_index     (bad_index),
    .bad_config    (bad_config),
    .unimpl_access (unimpl_access),
    .timer_run     (timer_run)
);

// File: tb/sim_rtc_index_regs.sv
`timescale 1ns/1ps
module sim_rtc_index_regs;

    localparam int IVL = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_we = 1'b0;
    logic [7:0] idx_wdata = '0;
    logic       dat_we = 1'b0;
    logic       dat_re = 1'b0;
    logic [7:0] dat_wdata = '0;
    logic [7:0] dat_rdata;
    logic       load_en = 1'b0;
    logic [7:0] load_sec = '0, load_min = '0, load_hour = '0;
    logic [2:0] load_wday = '0;
    logic [7:0] load_mday = '0, load_month = '0, load_year = '0;
    logic       irq, bad_index, bad_config, unimpl_access;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic done = 1'b0;

    rtc_index_regs #(.INTERVAL_CYCLES(IVL), .CAL_SLOTS(10)) u0 (
        .clk(clk), .rst_n(rst_n),
        .idx_we(idx_we), .idx_wdata(idx_wdata),
        .dat_we(dat_we), .dat_re(dat_re), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .load_en(load_en), .load_sec(load_sec), .load_min(load_min), .load_hour(load_hour),
        .load_wday(load_wday), .load_mday(load_mday), .load_month(load_month), .load_year(load_year),
        .irq(irq), .bad_index(bad_index), .bad_config(bad_config), .unimpl_access(unimpl_access)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_index(input logic [7:0] v);
        idx_we = 1'b1; idx_wdata = v;
        step();
        idx_we = 1'b0;
    endtask

    task automatic put_data(input logic [7:0] v);
        dat_we = 1'b1; dat_wdata = v;
        step();
        dat_we = 1'b0;
    endtask

    task automatic get_data(output logic [7:0] v);
        dat_re = 1'b1;
        v = dat_rdata;
        step();
        dat_re = 1'b0;
    endtask

    // Waits for an irq sample, returns its cycle, and checks it lasts one cycle
    task automatic wait_irq(input int limit, output int at);
        at = -1;
        for (int k = 0; k < limit; k++) begin
            if (irq) begin
                at = cyc;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        chk("R6 irq pulse one cycle", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R10 bad_index low", {31'b0, bad_index}, 0);
        chk("R10 bad_config low", {31'b0, bad_config}, 0);
        chk("R10 unimpl low", {31'b0, unimpl_access}, 0);
        chk("R10 irq low", {31'b0, irq}, 0);
        chk("R10 slot0 zero", {24'b0, dat_rdata}, 32'h00);
        set_index(8'h0A);
        chk("R3 A reset", {24'b0, dat_rdata}, 32'h26);
        set_index(8'h0B);
        chk("R4 B reset", {24'b0, dat_rdata}, 32'h46);
    endtask

    task automatic t_timer_from_reset();
        int at;
        wait_irq(4 * IVL, at);
        chk("R6 first irq after reset", at, IVL);
        wait_irq(4 * IVL, at);
        chk("R6 second irq period", at, 2 * IVL);
    endtask

    task automatic t_index();
        set_index(8'h05);
        chk("R1 legal index no flag", {31'b0, bad_index}, 0);
        set_index(8'h0E);
        chk("R1 index 0x0E flagged", {31'b0, bad_index}, 1);
        put_data(8'h5A);
        set_index(8'hFF);
        chk("R1 index 0xFF flagged", {31'b0, bad_index}, 1);
        chk("R1 index kept at 5", {24'b0, dat_rdata}, 32'h5A);
        set_index(8'h0D);
        chk("R1 index 0x0D accepted", {31'b0, bad_index}, 0);
    endtask

    task automatic t_bytes();
        logic [7:0] v;
        for (int i = 0; i < 10; i++) begin
            set_index(8'(i));
            put_data(8'(8'h10 + 3 * i));
        end
        for (int i = 0; i < 10; i++) begin
            set_index(8'(i));
            get_data(v);
            chk($sformatf("R2 slot %0d readback", i), {24'b0, v}, 32'(8'h10 + 3 * i));
        end
    endtask

    task automatic do_load(input logic [2:0] wd);
        load_sec = 8'h33; load_min = 8'h44; load_hour = 8'h17;
        load_wday = wd; load_mday = 8'h1C; load_month = 8'h02; load_year = 8'h63;
        load_en = 1'b1;
        step();
        load_en = 1'b0;
    endtask

    task automatic t_load();
        logic [7:0] exp [10];
        do_load(3'd6);
        exp = '{8'h33, 8'h13, 8'h44, 8'h19, 8'h17, 8'h1F, 8'h07, 8'h1C, 8'h02, 8'h63};
        for (int i = 0; i < 10; i++) begin
            set_index(8'(i));
            chk($sformatf("R9 slot %0d after load", i), {24'b0, dat_rdata}, {24'b0, exp[i]});
        end
        do_load(3'd0);
        set_index(8'h06);
        chk("R9 weekday 0 stored as 1", {24'b0, dat_rdata}, 32'h01);
    endtask

    task automatic t_reg_a();
        logic [7:0] v;
        set_index(8'h0A);
        get_data(v);
        chk("R7 first A read", {24'b0, v}, 32'h26);
        get_data(v);
        chk("R7 second A read toggled", {24'b0, v}, 32'hA6);
        get_data(v);
        chk("R7 third A read toggled back", {24'b0, v}, 32'h26);
        chk("R7 A after three reads", {24'b0, dat_rdata}, 32'hA6);
        put_data(8'h27);
        chk("R3 illegal A flagged", {31'b0, bad_config}, 1);
        chk("R3 illegal A ignored", {24'b0, dat_rdata}, 32'hA6);
        put_data(8'h26);
        chk("R3 legal A no flag", {31'b0, bad_config}, 0);
        chk("R3 legal A stored", {24'b0, dat_rdata}, 32'h26);
    endtask

    task automatic t_reg_b();
        set_index(8'h0B);
        put_data(8'h47);
        chk("R4 B 0x47 flagged", {31'b0, bad_config}, 1);
        chk("R4 B 0x47 ignored", {24'b0, dat_rdata}, 32'h46);
        put_data(8'h42);
        chk("R4 B without binary flagged", {31'b0, bad_config}, 1);
        chk("R4 B without binary ignored", {24'b0, dat_rdata}, 32'h46);
        put_data(8'h4E);
        chk("R4 B 0x4E no flag", {31'b0, bad_config}, 0);
        chk("R4 B 0x4E stored", {24'b0, dat_rdata}, 32'h4E);
    endtask

    task automatic t_stop_start();
        int seen;
        int c0;
        int at;
        int at2;
        set_index(8'h0B);
        put_data(8'h06);
        chk("R5 B disable stored", {24'b0, dat_rdata}, 32'h06);
        seen = 0;
        for (int k = 0; k < 3 * IVL; k++) begin
            if (irq) seen++;
            @(negedge clk);
        end
        chk("R5 no irq while disabled", seen, 0);
        c0 = cyc;
        put_data(8'h46);
        wait_irq(3 * IVL, at);
        chk("R6 first irq after start", at, c0 + 1 + IVL);
        while (cyc < at + IVL / 2) @(negedge clk);
        put_data(8'h4E);
        wait_irq(3 * IVL, at2);
        chk("R5 enable while running keeps phase", at2, at + IVL);
    endtask

    task automatic t_cd();
        logic [7:0] v;
        set_index(8'h0C);
        put_data(8'hFF);
        chk("R8 write C flagged", {31'b0, unimpl_access}, 1);
        chk("R8 C reads zero", {24'b0, dat_rdata}, 32'h00);
        set_index(8'h0D);
        get_data(v);
        chk("R8 read D value", {24'b0, v}, 32'h00);
        chk("R8 read D flagged", {31'b0, unimpl_access}, 1);
        set_index(8'h0A);
        chk("R8 A untouched by C write", {24'b0, dat_rdata}, 32'h26);
        set_index(8'h0B);
        chk("R8 B untouched by C write", {24'b0, dat_rdata}, 32'h4E);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timer_from_reset();
        t_index();
        t_bytes();
        t_load();
        t_reg_a();
        t_reg_b();
        t_stop_start();
        t_cd();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule